// File: doc/BRIEF.md
# Bit-Serial Four-Tap FIR with Runtime Precision

This block is a four-tap finite impulse response filter with fixed coefficients that uses no multiplier. A sixteen-entry table, filled through a write port before filtering starts, holds the sum of every subset of the four coefficients. For each output, the block walks through the bit positions of the four stored samples one position per clock cycle. At each position it takes that bit from all four samples, uses the four bits as a table address, and adds the selected entry into a shifting accumulator.

The walk starts at the sign bit and moves toward the least significant bit. Every partial result is therefore already a coarse version of the final answer. A precision input chooses how many bit positions (M, up to the sample width) are processed for the next output. A smaller M returns a lower-precision result sooner. The result is shifted back to full-precision scale, so consumers see the same numeric range at every setting.

One sample is accepted per output. The sample enters the delay line as the newest tap, and computation begins. No new sample is taken until the current result has been produced.

Top module: `msb_da_fir`

## Requirements
- R1: After reset, `res_valid` is low, `smp_ready` is high and every delay-line tap holds zero, so the first output after reset sees zero for all older taps.
- R2: Table entry `a` (written through `tbl_we`/`tbl_addr`/`tbl_data`) holds the signed sum of coefficient c_j over every j whose bit j of `a` is set. Address bit j carries the current bit of tap j, and tap 0 is the newest sample.
- R3: A sample is taken at a rising edge where `smp_valid` and `smp_ready` are both high. It becomes tap 0, and the older taps each move one place along the line.
- R4: At full precision, `res_data` equals the exact two's-complement inner product c0·x[n] + c1·x[n-1] + c2·x[n-2] + c3·x[n-3] of DW-bit signed samples.
- R5: A `prec` value from 1 to DW sets M to that value. A value of 0 or above DW selects M = DW.
- R6: `res_valid` is a single-cycle pulse that is first visible after the M-th rising edge following the accepting edge.
- R7: `smp_ready` is low from the accepting edge until the result is produced, and it is high in the cycle where `res_valid` is high.
- R8: With M below DW, `res_data` equals the inner product computed with each sample's lowest DW-M bits cleared. Its lowest DW-M bits are zero and its scale matches a full-precision result.
- R9: A table write made while a result is being computed is ignored, and the table keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry index |
| tbl_data | input | TW (10) | Signed partial coefficient sum to store |
| smp_valid | input | 1 | New sample offered |
| smp_data | input | DW (8) | Signed sample |
| smp_ready | output | 1 | Block idle, able to take a sample |
| prec | input | PW (4) | Precision M for the offered sample |
| res_valid | output | 1 | Result pulse |
| res_data | output | OW (18) | Signed filter output |

## Verification
The bench compares each output against an independent model of the delay line. Impulse inputs isolate each coefficient in turn and confirm that tap order matches address bits. Full-scale positive and negative samples stress the sign-slice subtraction and the widest accumulator values. A fixed mixed sample set run at several precisions separates correct bit truncation and rescaling from a wrong shift amount or wrong slice order. Runs of all-negative samples address the all-ones table entry while a write to that entry is attempted mid-computation.

// File: rtl/msb_da_fir_pkg.sv
package msb_da_fir_pkg;
    localparam int TAPS   = 4;
    localparam int ADDR_W = TAPS;
    localparam int TBL_N  = 1 << TAPS;

    // Map a raw precision request onto the number of bit cycles used.
    function automatic int eff_prec(input int p, input int dw);
        return (p == 0 || p > dw) ? dw : p;
    endfunction
endpackage

// File: rtl/msb_da_fir_taps.sv
module msb_da_fir_taps #(
    parameter int DW   = 8,
    parameter int TAPS = 4,
    parameter int BW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic [DW-1:0]   din,
    input  logic [BW-1:0]   bit_sel,
    output logic [TAPS-1:0] addr
);
    logic [DW-1:0] line_d [TAPS];
    logic [DW-1:0] line_q [TAPS];

    always_comb begin
        for (int i = 0; i < TAPS; i++) line_d[i] = line_q[i];
        if (shift_en) begin
            line_d[0] = din;
            for (int i = 1; i < TAPS; i++) line_d[i] = line_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) line_q[i] <= '0;
        end else begin
            for (int i = 0; i < TAPS; i++) line_q[i] <= line_d[i];
        end
    end

    // One address bit per tap, all taken at the same bit position
    for (genvar g = 0; g < TAPS; g++) begin : g_slice
        assign addr[g] = line_q[g][bit_sel];
    end
endmodule

// File: rtl/msb_da_fir_table.sv
module msb_da_fir_table #(
    parameter int TW = 10,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [TW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [TW-1:0] rdata
);
    localparam int N = 1 << AW;

    logic [TW-1:0] mem_d [N];
    logic [TW-1:0] mem_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/msb_da_fir.sv
module msb_da_fir
    import msb_da_fir_pkg::*;
#(
    parameter int  DW = 8,
    parameter int  CW = 8,
    localparam int TW = CW + $clog2(TAPS),
    localparam int OW = TW + DW,
    localparam int PW = $clog2(DW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [TW-1:0]     tbl_data,
    input  logic              smp_valid,
    input  logic [DW-1:0]     smp_data,
    output logic              smp_ready,
    input  logic [PW-1:0]     prec,
    output logic              res_valid,
    output logic [OW-1:0]     res_data
);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] TOP_POS = BW'(DW - 1);

    typedef struct packed {
        logic                 busy;
        logic [BW-1:0]        pos;
        logic [BW-1:0]        stop;
        logic signed [OW-1:0] acc;
        logic [OW-1:0]        res;
        logic                 vld;
    } state_t;

    state_t state_d, state_q;

    logic                 accept;
    logic [ADDR_W-1:0]    slice_addr;
    logic [TW-1:0]        tbl_rd;
    logic signed [OW-1:0] slice_val;
    logic signed [OW-1:0] acc_sh;

    assign accept    = !state_q.busy && smp_valid;
    assign slice_val = OW'($signed(tbl_rd));
    assign acc_sh    = state_q.acc <<< 1;

    msb_da_fir_taps #(.DW(DW), .TAPS(TAPS), .BW(BW)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (smp_data),
        .bit_sel  (state_q.pos),
        .addr     (slice_addr)
    );

    msb_da_fir_table #(.TW(TW), .AW(ADDR_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we && !state_q.busy),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (slice_addr),
        .rdata (tbl_rd)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        if (state_q.busy) begin
            // sign slice carries negative weight
            state_d.acc = (state_q.pos == TOP_POS) ? acc_sh - slice_val
                                                   : acc_sh + slice_val;
            if (state_q.pos == state_q.stop) begin
                state_d.busy = 1'b0;
                state_d.vld  = 1'b1;
                state_d.res  = state_d.acc <<< state_q.stop;
            end else begin
                state_d.pos = state_q.pos - 1'b1;
            end
        end else if (smp_valid) begin
            state_d.busy = 1'b1;
            state_d.pos  = TOP_POS;
            state_d.stop = BW'(DW - eff_prec(int'(prec), DW));
            state_d.acc  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign smp_ready = !state_q.busy;
    assign res_valid = state_q.vld;
    assign res_data  = state_q.res;
endmodule

// File: rtl/msb_da_fir_chk.sv
module msb_da_fir_chk
    import msb_da_fir_pkg::*;
#(
    parameter int DW = 8,
    parameter int OW = 18,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          smp_ready,
    input logic [PW-1:0] prec,
    input logic          res_valid,
    input logic [OW-1:0] res_data
);
    logic [PW:0]   left_q;
    logic          pend_q;
    logic [PW:0]   m_q;
    logic [OW-1:0] low_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            pend_q <= 1'b0;
            m_q    <= (PW+1)'(DW);
        end else if (smp_valid && smp_ready) begin
            left_q <= (PW+1)'(eff_prec(int'(prec), DW));
            m_q    <= (PW+1)'(eff_prec(int'(prec), DW));
            pend_q <= 1'b1;
        end else if (pend_q) begin
            left_q <= left_q - 1'b1;
            if (left_q == 1) pend_q <= 1'b0;
        end
    end

    assign low_mask = (OW'(1) << (DW - int'(m_q))) - OW'(1);

    // R6
    latency_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && left_q == 1) |=> res_valid);

    // R6
    no_stray_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(pend_q && left_q == 1));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R7
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !smp_ready);

    // R7
    ready_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> smp_ready);

    // R8
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_data & low_mask) == '0));
endmodule

bind msb_da_fir msb_da_fir_chk #(.DW(DW), .OW(OW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .prec      (prec),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/tb_msb_da_fir.sv
module tb_msb_da_fir;
    localparam int DW = 8;
    localparam int TW = 10;
    localparam int OW = 18;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_we = 1'b0;
    logic [3:0]    tbl_addr = '0;
    logic [TW-1:0] tbl_data = '0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          smp_ready;
    logic [PW-1:0] prec = '0;
    logic          res_valid;
    logic [OW-1:0] res_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int coef [4] = '{3, -7, 100, -128};
    int hist [4] = '{0, 0, 0, 0};

    always #10 clk = ~clk;

    msb_da_fir dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_ready(smp_ready), .prec(prec), .res_valid(res_valid),
        .res_data(res_data)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tbl_entry(input int a);
        int s = 0;
        for (int j = 0; j < 4; j++) if (a[j]) s += coef[j];
        return s;
    endfunction

    // R2: fill every entry with its subset sum, tap j on address bit j
    task automatic load_table();
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_addr = 4'(a); tbl_data = TW'(tbl_entry(a));
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Drives one sample, checks latency, ready and value against the model
    task automatic run_sample(input int x, input int p, input bit busy_wr,
                              input string req);
        int m, s, exp, n, xt;
        bit ready_bad;
        m = (p == 0 || p > DW) ? DW : p;
        s = DW - m;
        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        exp = 0;
        for (int j = 0; j < 4; j++) begin
            xt = (hist[j] >>> s) <<< s;
            exp += coef[j] * xt;
        end
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1; smp_data = DW'(x); prec = PW'(p);
        @(posedge clk);
        n = 0;
        ready_bad = 0;
        forever begin
            @(negedge clk);
            n++;
            smp_valid = 1'b0;
            if (busy_wr && n == 1) begin
                tbl_we = 1'b1; tbl_addr = 4'hF; tbl_data = TW'(10'h155);
            end
            if (busy_wr && n == 2) tbl_we = 1'b0;
            if (res_valid || n > 40) break;
            if (smp_ready) ready_bad = 1;
        end
        tbl_we = 1'b0;
        check({req, " latency R6"}, n - 1, m);
        check({req, " ready low while busy R7"}, int'(ready_bad), 0);
        check({req, " value"}, int'($signed(res_data)), exp);
        check({req, " ready with result R7"}, int'(smp_ready), 1);
        @(negedge clk);
        check({req, " pulse width R6"}, int'(res_valid), 0);
    endtask

    task automatic test_reset();
        check("R1 res_valid after reset", int'(res_valid), 0);
        check("R1 ready after reset", int'(smp_ready), 1);
    endtask

    task automatic test_impulse();
        // R1 older taps zero, R3 ordering, R4 exact
        run_sample(1, DW, 0, "R3 impulse tap0");
        run_sample(0, DW, 0, "R3 impulse tap1");
        run_sample(0, DW, 0, "R3 impulse tap2");
        run_sample(0, DW, 0, "R3 impulse tap3");
        run_sample(0, DW, 0, "R4 impulse flushed");
    endtask

    task automatic test_extremes();
        run_sample(-128, DW, 0, "R4 min");
        run_sample(127, DW, 0, "R4 max");
        run_sample(-128, DW, 0, "R4 min again");
        run_sample(127, DW, 0, "R4 max again");
        run_sample(-1, DW, 0, "R4 minus one");
    endtask

    task automatic test_truncation();
        run_sample(93, DW, 0, "R4 mixed");
        run_sample(-77, DW, 0, "R4 mixed");
        run_sample(45, DW, 0, "R4 mixed");
        run_sample(-3, 1, 0, "R8 M=1");
        run_sample(-3, 3, 0, "R8 M=3");
        run_sample(110, 5, 0, "R8 M=5");
        run_sample(-99, 7, 0, "R8 M=7");
        run_sample(61, 2, 0, "R8 M=2");
    endtask

    task automatic test_prec_decode();
        run_sample(-50, 0, 0, "R5 prec zero");
        run_sample(77, 12, 0, "R5 prec above DW");
        run_sample(12, DW, 0, "R5 prec equal DW");
    endtask

    task automatic test_busy_write();
        for (int i = 0; i < 4; i++) run_sample(-1, DW, 0, "R9 setup");
        run_sample(-1, DW, 1, "R9 write during busy");
        run_sample(-1, DW, 0, "R9 entry intact");
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        load_table();
        test_impulse();
        test_extremes();
        test_truncation();
        test_prec_decode();
        test_busy_write();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule